// File: doc/BRIEF.md
# Target Block-Move Byte Counter

This block carries out one block-move instruction while the chip acts as a target on a parallel SCSI-style bus. A start pulse hands it the instruction: a three-bit phase field, a move-type bit, a programmed byte count and a start address. If the chip is connected as a target, the block drives the three bus phase lines from the phase field. It then accepts bytes one at a time on a valid/ready stream. Each accepted byte appears as a write strobe with its address and data, and the count runs down to zero.

In command phase (phase field 3'b010) the first byte is a command opcode. Its group code, bits 7:5 of that byte, can replace the programmed count with the standard command-block length. A configuration input controls how the vendor-unique groups are handled. A transfer with nothing to move raises an illegal-instruction interrupt in place of a transfer.

Back-pressure: `in_ready` is high for the whole of a transfer and low at all other times. A byte moves only in a cycle where `in_valid` and `in_ready` are both high. While `in_valid` is low, the count and the address hold, and the source may hold off for any number of cycles. The write side has no stall.

Top module: `tgt_blkmove`

## Requirements
- R1: A `start` pulse is acted on only when `is_target` is high and the block is idle. Otherwise it is ignored: `busy` and `in_ready` stay low.
- R2: While busy, `ph_msg`, `ph_cd` and `ph_io` equal bits 2, 1 and 0 of the phase field latched at start. All three are low while idle.
- R3: In command phase (field 3'b010), the group code (bits 7:5 of the first accepted byte) sets the total byte count, first byte included: group 0 gives 6, groups 1 and 2 give 10, group 5 gives 12.
- R4: Groups 6 and 7 give 6 bytes when `vu_keep` is low. When `vu_keep` is high they use the programmed count.
- R5: Groups 3 and 4 use the programmed count unchanged, and exactly that many bytes are taken.
- R6: If the count that applies is zero, `illegal_irq` rises and no byte is written. Outside command phase this happens straight after start. In command phase the first byte is consumed without a write. `illegal_irq` stays high until the next accepted start and never coincides with `done`.
- R7: Each accepted byte produces one `wr_en` cycle, with `wr_data` equal to that byte. `wr_addr` is the programmed address plus the number of bytes accepted before it. Each accepted byte lowers `cur_count` by one.
- R8: `done` is high for exactly the one cycle after the last byte is accepted. By then `cur_count` is 0 and `in_ready` is low.
- R9: `chained` shows the move-type bit (instruction bit 27: 0 = plain move, 1 = chained move) latched at start.
- R10: A synchronous active-high `rst` makes the block idle, with the phase lines, `in_ready`, `done` and `illegal_irq` all low.
- R11: During a transfer, cycles with `in_valid` low change neither `cur_count` nor the address, and `in_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to execute the presented instruction |
| instr_opc | input | 1 | Move-type bit (instruction bit 27) |
| phase_fld | input | 3 | Phase field: bit 2 message, bit 1 control/data, bit 0 input/output |
| prog_count | input | CNT_W (24) | Programmed byte count |
| prog_addr | input | ADDR_W (32) | Start address of the transfer |
| is_target | input | 1 | High when connected to the bus as a target |
| vu_keep | input | 1 | High: vendor-unique groups keep the programmed count |
| in_valid | input | 1 | Byte present on `in_data` |
| in_data | input | 8 | Received byte |
| in_ready | output | 1 | Block can accept a byte |
| wr_en | output | 1 | Byte write strobe |
| wr_addr | output | ADDR_W (32) | Address of the byte being written; after a transfer, the next address |
| wr_data | output | 8 | Byte being written |
| ph_msg | output | 1 | Message phase line |
| ph_cd | output | 1 | Control/data phase line |
| ph_io | output | 1 | Input/output phase line |
| busy | output | 1 | Transfer in progress |
| chained | output | 1 | Latched move-type bit |
| cur_count | output | CNT_W (24) | Bytes still to transfer |
| done | output | 1 | One-cycle completion pulse |
| illegal_irq | output | 1 | Illegal-instruction interrupt |

## Verification
The assertions assume three things about the inputs. `rst` is applied before the first check. `vu_keep` does not change while the block waits for a command opcode. `start` is the only way a new instruction enters, so instruction inputs seen while busy have no meaning. The stimulus changes `is_target`, `vu_keep` and the instruction fields only while the block is idle, one clock edge ahead of `start`. It drives `in_valid` and `in_data` only just after a rising edge. Some transfers include idle gaps on the stream, and those gaps occur only inside a transfer.

// File: rtl/tgt_blkmove_pkg.sv
package tgt_blkmove_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OPCODE = 2'd1,
    ST_MOVE = 2'd2
  } mv_state_e;

  localparam logic [2:0] PH_COMMAND = 3'b010;
endpackage

// File: rtl/tgt_cdb_len.sv
// Maps the group code of a command opcode to the total command-block length.
module tgt_cdb_len #(
  parameter int CNT_W = 24
) (
  input  logic [2:0]       grp,
  input  logic [CNT_W-1:0] prog,
  input  logic             vu_keep,
  output logic [CNT_W-1:0] len
);
  localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(6);
  localparam logic [CNT_W-1:0] LEN_MID   = CNT_W'(10);
  localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(12);

  always_comb begin
    case (grp)
      3'd0:       len = LEN_SHORT;
      3'd1, 3'd2: len = LEN_MID;
      3'd5:       len = LEN_LONG;
      3'd6, 3'd7: len = vu_keep ? prog : LEN_SHORT;
      default:    len = prog;
    endcase
  end
endmodule

// File: rtl/tgt_xfer_ctr.sv
// Byte count and address registers of one transfer.
module tgt_xfer_ctr #(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  input  logic              reload,
  input  logic [CNT_W-1:0]  reload_cnt,
  output logic [CNT_W-1:0]  cnt,
  output logic [ADDR_W-1:0] addr
);
  logic [CNT_W-1:0] base;

  assign base = reload ? reload_cnt : cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      addr <= '0;
    end else if (load) begin
      cnt  <= load_cnt;
      addr <= load_addr;
    end else if (step) begin
      cnt  <= base - CNT_W'(1);
      addr <= addr + ADDR_W'(1);
    end
  end

  // R7: every moved byte advances the address by one
  assert_addr_step_R7: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> addr == $past(addr) + ADDR_W'(1));

  // R7: outside the opcode byte, a moved byte lowers the count by one
  assert_cnt_step_R7: assert property (@(posedge clk) disable iff (rst)
    (step && !load && !reload) |=> cnt == $past(cnt) - CNT_W'(1));

  // R11: no load and no step leaves both registers alone
  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> ($stable(cnt) && $stable(addr)));
endmodule

// File: rtl/tgt_move_ctl.sv
// Sequencer: idle, waiting for the command opcode, moving bytes.
module tgt_move_ctl
  import tgt_blkmove_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic is_target,
  input  logic ph_cmd,
  input  logic prog_zero,
  input  logic in_valid,
  input  logic last_byte,
  input  logic first_zero,
  input  logic first_one,
  output logic load,
  output logic step,
  output logic reload,
  output logic busy,
  output logic in_ready,
  output logic done,
  output logic illegal_irq
);
  mv_state_e st;
  logic go, acc, opc_phase;

  assign opc_phase = (st == ST_OPCODE);
  assign busy      = (st != ST_IDLE);
  assign in_ready  = busy;
  assign go        = (st == ST_IDLE) && start && is_target;
  assign acc       = in_valid && in_ready;
  assign load      = go;
  assign reload    = opc_phase;
  assign step      = acc && !(opc_phase && first_zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      done        <= 1'b0;
      illegal_irq <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (go) begin
          illegal_irq <= 1'b0;
          if (ph_cmd)         st          <= ST_OPCODE;
          else if (prog_zero) illegal_irq <= 1'b1;
          else                st          <= ST_MOVE;
        end
        ST_OPCODE: if (acc) begin
          if (first_zero) begin
            illegal_irq <= 1'b1;
            st          <= ST_IDLE;
          end else if (first_one) begin
            done <= 1'b1;
            st   <= ST_IDLE;
          end else begin
            st <= ST_MOVE;
          end
        end
        ST_MOVE: if (acc && last_byte) begin
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R1: a start without a target connection leaves the block idle
  assert_need_target_R1: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && !is_target) |=> !busy);

  // R8: completion is a single-cycle pulse seen after leaving the transfer
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !in_ready);

  // R6: an illegal instruction never also completes
  assert_irq_no_done_R6: assert property (@(posedge clk) disable iff (rst)
    illegal_irq |-> !done);

  // R11: an idle stream cycle never ends a transfer
  assert_stall_busy_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && !in_valid) |=> busy);
endmodule

// File: rtl/tgt_blkmove.sv
// Target-mode block move: phase drive, command-length rewrite, byte counting.
module tgt_blkmove #(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              instr_opc,
  input  logic [2:0]        phase_fld,
  input  logic [CNT_W-1:0]  prog_count,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic              is_target,
  input  logic              vu_keep,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              ph_msg,
  output logic              ph_cd,
  output logic              ph_io,
  output logic              busy,
  output logic              chained,
  output logic [CNT_W-1:0]  cur_count,
  output logic              done,
  output logic              illegal_irq
);
  import tgt_blkmove_pkg::*;

  localparam int GRP_LSB = DATA_W - 3;

  logic             load, step, reload;
  logic [CNT_W-1:0] first_len;
  logic [2:0]       phase_q;
  logic             chain_q;

  tgt_cdb_len #(.CNT_W(CNT_W)) u_len (
    .grp     (in_data[DATA_W-1:GRP_LSB]),
    .prog    (cur_count),
    .vu_keep (vu_keep),
    .len     (first_len)
  );

  tgt_move_ctl u_ctl (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .is_target   (is_target),
    .ph_cmd      (phase_fld == PH_COMMAND),
    .prog_zero   (prog_count == '0),
    .in_valid    (in_valid),
    .last_byte   (cur_count == CNT_W'(1)),
    .first_zero  (first_len == '0),
    .first_one   (first_len == CNT_W'(1)),
    .load        (load),
    .step        (step),
    .reload      (reload),
    .busy        (busy),
    .in_ready    (in_ready),
    .done        (done),
    .illegal_irq (illegal_irq)
  );

  tgt_xfer_ctr #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .load_cnt   (prog_count),
    .load_addr  (prog_addr),
    .step       (step),
    .reload     (reload),
    .reload_cnt (first_len),
    .cnt        (cur_count),
    .addr       (wr_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      chain_q <= 1'b0;
    end else if (load) begin
      phase_q <= phase_fld;
      chain_q <= instr_opc;
    end
  end

  assign wr_en   = step;
  assign wr_data = in_data;
  assign chained = chain_q;
  assign ph_msg  = busy & phase_q[2];
  assign ph_cd   = busy & phase_q[1];
  assign ph_io   = busy & phase_q[0];

  // R2: the phase lines do not move in the middle of a transfer
  assert_phase_steady_R2: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy || $stable({ph_msg, ph_cd, ph_io})));

  // R6: a raised interrupt means the count was left at zero
  assert_irq_count_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(illegal_irq) |-> cur_count == '0);
endmodule

// File: tb/tgt_blkmove_test.sv
`timescale 1ns/1ps
module tgt_blkmove_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, instr_opc = 1'b0, is_target = 1'b1, vu_keep = 1'b0;
  logic [2:0]  phase_fld = '0;
  logic [23:0] prog_count = '0;
  logic [31:0] prog_addr = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, wr_en, ph_msg, ph_cd, ph_io, busy, chained, done, illegal_irq;
  logic [31:0] wr_addr;
  logic [7:0]  wr_data;
  logic [23:0] cur_count;

  int checks = 0;
  int errors = 0;
  logic [39:0] sb[$];

  always #2.5 clk = ~clk;

  tgt_blkmove uut (
    .clk(clk), .rst(rst), .start(start), .instr_opc(instr_opc), .phase_fld(phase_fld),
    .prog_count(prog_count), .prog_addr(prog_addr), .is_target(is_target),
    .vu_keep(vu_keep), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .ph_msg(ph_msg), .ph_cd(ph_cd),
    .ph_io(ph_io), .busy(busy), .chained(chained), .cur_count(cur_count), .done(done),
    .illegal_irq(illegal_irq)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor: every write strobe must match the next expected byte (R7)
  always @(negedge clk) begin
    if (!rst && wr_en) begin
      if (sb.size() == 0) begin
        chk("R7", "unexpected write", 1, 0);
      end else begin
        logic [39:0] e;
        e = sb.pop_front();
        chk("R7", "write address", wr_addr, e[39:8]);
        chk("R7", "write data", wr_data, e[7:0]);
      end
    end
  end

  function automatic int exp_total(input logic [2:0] ph, input logic [23:0] cnt,
                                   input logic [7:0] b, input logic vu);
    if (ph != 3'b010) return int'(cnt);
    case (b[7:5])
      3'd0:       return 6;
      3'd1, 3'd2: return 10;
      3'd5:       return 12;
      3'd6, 3'd7: return vu ? int'(cnt) : 6;
      default:    return int'(cnt);
    endcase
  endfunction

  // called just after a rising edge; returns just after the edge that took the byte
  task automatic send_byte(input logic [7:0] d);
    logic r;
    in_valid = 1'b1;
    in_data  = d;
    forever begin
      @(negedge clk);
      r = in_ready;
      @(posedge clk);
      #1;
      if (r) break;
    end
  endtask

  task automatic launch(input logic opc, input logic [2:0] ph, input logic [23:0] cnt,
                        input logic [31:0] a);
    @(posedge clk);
    #1;
    instr_opc = opc; phase_fld = ph; prog_count = cnt; prog_addr = a; start = 1'b1;
    @(posedge clk);
    #1;
    start = 1'b0;
  endtask

  task automatic xfer(input logic opc, input logic [2:0] ph, input logic [23:0] cnt,
                      input logic [31:0] a, input logic vu, input logic [7:0] b0,
                      input logic gap, input string req);
    int n;
    logic [23:0] held;
    vu_keep = vu;
    n = exp_total(ph, cnt, b0, vu);
    launch(opc, ph, cnt, a);
    chk("R9", "chained bit", chained, opc);
    if (ph == 3'b010 || n != 0) begin
      chk("R2", "phase lines", {ph_msg, ph_cd, ph_io}, ph);
      chk("R6", "interrupt cleared by start", illegal_irq, 0);
    end
    if (n == 0) begin
      if (ph == 3'b010) begin
        send_byte(b0);
        in_valid = 1'b0;
      end
      chk("R6", "illegal interrupt", illegal_irq, 1);
      chk("R6", "idle after illegal", busy, 0);
      chk("R6", "count left zero", cur_count, 0);
      chk("R6", "no done", done, 0);
      return;
    end
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = (i == 0) ? b0 : 8'(i * 7 + 3);
      if (gap && i == 2) begin
        held = cur_count;
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R11", "count held during stall", cur_count, held);
        chk("R11", "ready held during stall", in_ready, 1);
      end
      sb.push_back({32'(a + 32'(i)), d});
      send_byte(d);
      if (i < n - 1) chk("R8", "no early done", done, 0);
    end
    in_valid = 1'b0;
    chk("R8", "done pulse", done, 1);
    chk("R8", "ready low after last byte", in_ready, 0);
    chk(req, "count reached zero", cur_count, 0);
    chk(req, "final address", wr_addr, a + 32'(n));
    @(posedge clk);
    #1;
    chk("R8", "done one cycle only", done, 0);
    chk("R2", "phase lines idle", {ph_msg, ph_cd, ph_io}, 0);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    rst = 1'b0;
    chk("R10", "phase lines at reset", {ph_msg, ph_cd, ph_io}, 0);
    chk("R10", "ready at reset", in_ready, 0);
    chk("R10", "irq at reset", illegal_irq, 0);
    chk("R10", "done at reset", done, 0);

    xfer(1'b0, 3'b000, 24'd4, 32'h100, 1'b0, 8'h11, 1'b0, "R7");
    xfer(1'b1, 3'b111, 24'd5, 32'h200, 1'b0, 8'h22, 1'b1, "R11");
    xfer(1'b0, 3'b010, 24'd20, 32'h300, 1'b0, 8'h08, 1'b0, "R3");
    xfer(1'b0, 3'b010, 24'd2, 32'h400, 1'b0, 8'h28, 1'b0, "R3");
    xfer(1'b1, 3'b010, 24'd0, 32'h500, 1'b0, 8'h5A, 1'b0, "R3");
    xfer(1'b0, 3'b010, 24'd1, 32'h600, 1'b0, 8'hA8, 1'b1, "R3");
    xfer(1'b0, 3'b010, 24'd30, 32'h700, 1'b0, 8'hC0, 1'b0, "R4");
    xfer(1'b0, 3'b010, 24'd3, 32'h800, 1'b1, 8'hE5, 1'b0, "R4");
    xfer(1'b0, 3'b010, 24'd4, 32'h900, 1'b0, 8'h7F, 1'b0, "R5");
    xfer(1'b0, 3'b010, 24'd1, 32'hA00, 1'b0, 8'h9A, 1'b0, "R5");
    xfer(1'b0, 3'b010, 24'd0, 32'hB00, 1'b0, 8'h9A, 1'b0, "R6");
    xfer(1'b0, 3'b001, 24'd0, 32'hC00, 1'b0, 8'h00, 1'b0, "R6");
    xfer(1'b0, 3'b010, 24'd0, 32'hD00, 1'b1, 8'hF0, 1'b0, "R6");
    xfer(1'b0, 3'b011, 24'd2, 32'hE00, 1'b0, 8'h33, 1'b0, "R7");

    is_target = 1'b0;
    launch(1'b1, 3'b110, 24'd3, 32'hF00);
    chk("R1", "busy without target", busy, 0);
    chk("R1", "ready without target", in_ready, 0);
    chk("R1", "phase lines without target", {ph_msg, ph_cd, ph_io}, 0);
    is_target = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("R1", "no stray done", done, 0);
    chk("R7", "scoreboard drained", sb.size(), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule